// File: doc/BRIEF.md
# Chip-Rate Correlator Coprocessor

This block is one shared despreading engine for a CDMA receiver. Complex chip samples, each with a two-bit scrambling sign pair, come straight from the radio front end into a double-buffered input stage. The samples are grouped into vectors of `CHIPS` samples. A host processor programs a small table of task descriptors through a memory-mapped port. Each descriptor turns one slot of the engine into a rake finger or a correlation probe.

Each time a vector is complete, a sequencer sweeps every table slot in ascending order, one slot per clock. An enabled task correlates the whole vector in one cycle. It removes the scrambling code and the OVSF channelization code, adds the result to its own saturating complex accumulator, and writes one despread symbol into its private ring in the output memory each time its spreading factor is reached. A task keeps running on every later vector until the host rewrites its slot. The host reads the symbols back through the same port.

Top module: `corr_engine`

## Requirements
- R1: After reset, `overrun` is 0, every task is disabled and every output memory word reads back as zero.
- R2: A vector is complete on the clock that accepts its `CHIPS`-th valid chip. The next clock starts a sweep that handles slots 0 to `TASKS`-1 in ascending order, one per clock. A vector that completes on the clock of the last slot starts the next sweep at once.
- R3: An enabled task processes every accepted vector until its slot is rewritten. A slot whose enable bit is 0 changes neither its state nor the output memory.
- R4: A descriptor is one 32-bit word with these fields: bit 0 enable, bits 4:1 log2(SF), bits 13:5 code index, bits 18:14 chip offset, bits 25:19 output base, bits 31:26 ring length minus one. log2(SF) must lie in 2..9 and must be at least log2(`CHIPS`).
- R5: For a chip with sample I+jQ and sign bits s0 (I part, 1 = -1) and s1 (Q part, 1 = -1), the despread term is I·sI+Q·sQ on the real side and Q·sI−I·sQ on the imaginary side. This term is multiplied by the OVSF chip.
- R6: The OVSF chip at symbol position j is -1 when the parity of (code AND reverse(j)) is odd, and +1 otherwise. Both reverse(j) and the code are taken over log2(SF) bits.
- R7: The position counter runs 0 to SF−1. On the chip at position SF−1 the accumulated value is stored as one symbol, and the accumulator and the position restart at zero.
- R8: On the first vector after a descriptor write, chips at vector positions below the offset are skipped. Every later vector is used in full.
- R9: The accumulators are ACC_W-bit signed values. They saturate after each chip is added, in chip order within the vector.
- R10: Symbols of a task go to output address (base + k) mod `OUT_DEPTH`. The index k counts 0..length−1 and then wraps to 0.
- R11: If a vector completes while a sweep is running and not on its last slot, that vector is dropped and `overrun` becomes 1. It stays 1 until reset.
- R12: A descriptor write clears that task's accumulators, position and ring index, and re-arms its offset.
- R13: `hostAddr[ADDR_W-1]` picks the region: 0 is the task table, 1 is the output memory. Read data appears one clock after `hostRd`. A symbol reads as I in bits ACC_W−1:0 and Q in bits 16+ACC_W−1:16, with all other bits zero. A descriptor reads back as it was written. Writes to the output region are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipValid | input | 1 | Chip sample valid |
| chipI | input | SAMP_W | Signed in-phase sample |
| chipQ | input | SAMP_W | Signed quadrature sample |
| chipScr | input | 2 | Scrambling sign pair (bit 0 I, bit 1 Q, 1 = negative) |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Host word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Registered host read data |
| overrun | output | 1 | Sticky flag: a vector was dropped |

## Verification
The bench drives a six-slot, ten-bit-accumulator configuration through several hundred vectors, mostly pseudo-random, and compares the whole output memory against an arithmetic model at several points.

- **Code generation.** The codes cover several spreading factors. If bit reversal or code masking is wrong, the symbol values are off.
- **Chip offset.** Offsets shift symbol boundaries inside a vector. A design that applied the offset on every vector would lose chips.
- **Ring wrap.** One ring wraps past the top of memory. A wrong wrap would overwrite a neighbouring task's symbols.
- **Saturation.** Long runs of full-scale samples test saturation. A design that clamps only at dump time, or lets the sum wrap, stores a wrong sign.
- **Rewrite and disable.** Rewriting a live slot and clearing an enable must restart or freeze that task; stale state would corrupt its later symbols.
- **Overrun.** A back-to-back burst must raise the sticky overrun flag while gapped traffic must not.

// File: rtl/corr_pkg.sv
package corr_pkg;

  localparam int SLOT_W = 8;

  // host-visible descriptor, bit 0 is the enable
  typedef struct packed {
    logic [5:0] lenM1;
    logic [6:0] base;
    logic [4:0] offset;
    logic [8:0] code;
    logic [3:0] lsf;
    logic       en;
  } taskDesc_t;

  // control to datapath strobes
  typedef struct packed {
    logic              run;
    logic [SLOT_W-1:0] slot;
    logic              descWr;
    logic [SLOT_W-1:0] descSlot;
  } ctrlStrobe_t;

  // returns 1 when the channelization chip is -1
  function automatic logic ovsfNeg(input logic [8:0] code, input logic [8:0] idx,
                                   input logic [3:0] lsf);
    logic [8:0] rev;
    rev = '0;
    for (int b = 0; b < 9; b++) begin
      if (b < int'(lsf)) rev[int'(lsf) - 1 - b] = idx[b];
    end
    return ^(code & rev);
  endfunction

endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int CHIPS  = 4,
  parameter int TASKS  = 4,
  parameter int SAMP_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         chipValid,
  input  logic [SAMP_W-1:0]            chipI,
  input  logic [SAMP_W-1:0]            chipQ,
  input  logic [1:0]                   chipScr,
  input  logic                         hostWr,
  input  logic [ADDR_W-1:0]            hostAddr,
  output logic [CHIPS-1:0][SAMP_W-1:0] workI,
  output logic [CHIPS-1:0][SAMP_W-1:0] workQ,
  output logic [CHIPS-1:0][1:0]        workScr,
  output ctrlStrobe_t                  strobe,
  output logic                         overrun
);

  localparam int CNT_W = (CHIPS > 1) ? $clog2(CHIPS) : 1;

  logic [CHIPS-1:0][SAMP_W-1:0] fillI, fillQ;
  logic [CHIPS-1:0][1:0]        fillScr;
  logic [CNT_W-1:0]             fillCnt;
  logic                         run;
  logic [SLOT_W-1:0]            slot;
  logic                         vecDone, lastSlot, canStart, descHit;

  assign vecDone  = chipValid && (fillCnt == CNT_W'(CHIPS - 1));
  assign lastSlot = run && (slot == SLOT_W'(TASKS - 1));
  assign canStart = !run || lastSlot;
  assign descHit  = hostWr && !hostAddr[ADDR_W-1] &&
                    (hostAddr[ADDR_W-2:0] < (ADDR_W-1)'(TASKS));

  assign strobe = '{run: run, slot: slot, descWr: descHit,
                    descSlot: SLOT_W'(hostAddr[ADDR_W-2:0])};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillI   <= '0;
      fillQ   <= '0;
      fillScr <= '0;
      workI   <= '0;
      workQ   <= '0;
      workScr <= '0;
      fillCnt <= '0;
      run     <= 1'b0;
      slot    <= '0;
      overrun <= 1'b0;
    end else begin
      if (chipValid) begin
        fillI[fillCnt]   <= chipI;
        fillQ[fillCnt]   <= chipQ;
        fillScr[fillCnt] <= chipScr;
        fillCnt          <= vecDone ? '0 : fillCnt + 1'b1;
      end
      if (vecDone && canStart) begin
        for (int p = 0; p < CHIPS; p++) begin
          workI[p]   <= (p == CHIPS - 1) ? chipI   : fillI[p];
          workQ[p]   <= (p == CHIPS - 1) ? chipQ   : fillQ[p];
          workScr[p] <= (p == CHIPS - 1) ? chipScr : fillScr[p];
        end
        run  <= 1'b1;
        slot <= '0;
      end else if (run) begin
        if (lastSlot) run <= 1'b0;
        else          slot <= slot + 1'b1;
      end
      if (vecDone && !canStart) overrun <= 1'b1;
    end
  end

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R11
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(chipValid) && $past(run));

  // R2
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && (slot != SLOT_W'(TASKS - 1))) |=> run && (slot == $past(slot) + 1'b1));

endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import corr_pkg::*;
#(
  parameter int CHIPS     = 4,
  parameter int TASKS     = 4,
  parameter int SAMP_W    = 8,
  parameter int ACC_W     = 16,
  parameter int OUT_DEPTH = 32,
  parameter int ADDR_W    = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic [CHIPS-1:0][SAMP_W-1:0] workI,
  input  logic [CHIPS-1:0][SAMP_W-1:0] workQ,
  input  logic [CHIPS-1:0][1:0]        workScr,
  input  logic                         hostRd,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic [31:0]                  hostWdata,
  output logic [31:0]                  hostRdata
);

  localparam int MEM_AW = $clog2(OUT_DEPTH);
  localparam int TASK_W = (TASKS > 1) ? $clog2(TASKS) : 1;
  localparam int LOG2C  = $clog2(CHIPS);
  localparam int WIDE   = ACC_W + SAMP_W + 2;
  localparam logic signed [WIDE-1:0] ACC_MAX = WIDE'((1 << (ACC_W - 1)) - 1);
  localparam logic signed [WIDE-1:0] ACC_MIN = -ACC_MAX - 1;

  taskDesc_t               descTab [TASKS];
  logic signed [ACC_W-1:0] accI    [TASKS];
  logic signed [ACC_W-1:0] accQ    [TASKS];
  logic [8:0]              phase   [TASKS];
  logic [5:0]              wrIdx   [TASKS];
  logic [TASKS-1:0]        started;
  logic [2*ACC_W-1:0]      outMem  [OUT_DEPTH];

  logic [TASK_W-1:0]       cur, dSlot;
  taskDesc_t               curDesc;
  logic signed [ACC_W-1:0] nxtI, nxtQ, dumpI, dumpQ;
  logic [8:0]              nxtPh;
  logic                    dumpHit, busyHit;
  logic [9:0]              sfM1;
  logic signed [WIDE-1:0]  xi, xq, tI, tQ;
  logic [MEM_AW-1:0]       memAddr;
  logic [31:0]             readWord;

  assign cur     = TASK_W'(strobe.slot);
  assign dSlot   = TASK_W'(strobe.descSlot);
  assign curDesc = descTab[cur];
  assign busyHit = strobe.run && curDesc.en && !(strobe.descWr && dSlot == cur);
  assign memAddr = MEM_AW'({1'b0, curDesc.base} + {2'b0, wrIdx[cur]});

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [WIDE-1:0] x);
    if (x > ACC_MAX) return ACC_W'(ACC_MAX);
    if (x < ACC_MIN) return ACC_W'(ACC_MIN);
    return ACC_W'(x);
  endfunction

  // one task over the whole vector, chip after chip
  always_comb begin
    nxtI    = accI[cur];
    nxtQ    = accQ[cur];
    nxtPh   = phase[cur];
    dumpHit = 1'b0;
    dumpI   = '0;
    dumpQ   = '0;
    xi      = '0;
    xq      = '0;
    tI      = '0;
    tQ      = '0;
    sfM1    = (10'd1 << curDesc.lsf) - 10'd1;
    for (int p = 0; p < CHIPS; p++) begin
      if (started[cur] || p >= int'(curDesc.offset)) begin
        xi = WIDE'($signed(workI[p]));
        xq = WIDE'($signed(workQ[p]));
        tI = (workScr[p][0] ? -xi : xi) + (workScr[p][1] ? -xq : xq);
        tQ = (workScr[p][0] ? -xq : xq) - (workScr[p][1] ? -xi : xi);
        if (ovsfNeg(curDesc.code, nxtPh, curDesc.lsf)) begin
          tI = -tI;
          tQ = -tQ;
        end
        nxtI = sat(WIDE'(nxtI) + tI);
        nxtQ = sat(WIDE'(nxtQ) + tQ);
        if ({1'b0, nxtPh} == sfM1) begin
          dumpHit = 1'b1;
          dumpI   = nxtI;
          dumpQ   = nxtQ;
          nxtI    = '0;
          nxtQ    = '0;
          nxtPh   = '0;
        end else begin
          nxtPh = nxtPh + 1'b1;
        end
      end
    end
  end

  always_comb begin
    readWord = '0;
    if (hostAddr[ADDR_W-1]) begin
      readWord[ACC_W-1:0]       = outMem[hostAddr[MEM_AW-1:0]][ACC_W-1:0];
      readWord[16+ACC_W-1:16]   = outMem[hostAddr[MEM_AW-1:0]][2*ACC_W-1:ACC_W];
    end else if (hostAddr[ADDR_W-2:0] < (ADDR_W-1)'(TASKS)) begin
      readWord = descTab[TASK_W'(hostAddr[ADDR_W-2:0])];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < TASKS; t++) begin
        descTab[t] <= '0;
        accI[t]    <= '0;
        accQ[t]    <= '0;
        phase[t]   <= '0;
        wrIdx[t]   <= '0;
      end
      started <= '0;
      for (int m = 0; m < OUT_DEPTH; m++) outMem[m] <= '0;
      hostRdata <= '0;
    end else begin
      if (busyHit) begin
        accI[cur]    <= nxtI;
        accQ[cur]    <= nxtQ;
        phase[cur]   <= nxtPh;
        started[cur] <= 1'b1;
        if (dumpHit) begin
          outMem[memAddr] <= {dumpQ, dumpI};
          wrIdx[cur]      <= (wrIdx[cur] == curDesc.lenM1) ? '0 : wrIdx[cur] + 1'b1;
        end
      end
      if (strobe.descWr) begin
        descTab[dSlot] <= hostWdata;
        accI[dSlot]    <= '0;
        accQ[dSlot]    <= '0;
        phase[dSlot]   <= '0;
        wrIdx[dSlot]   <= '0;
        started[dSlot] <= 1'b0;
      end
      if (hostRd) hostRdata <= readWord;
    end
  end

  // R4
  sf_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyHit |-> (curDesc.lsf >= 4'd2) && (curDesc.lsf <= 4'd9) &&
                (int'(curDesc.lsf) >= LOG2C));

  // R12
  desc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.descWr |=> (phase[$past(dSlot)] == '0) && (wrIdx[$past(dSlot)] == '0) &&
                      !started[$past(dSlot)]);

  for (genvar t = 0; t < TASKS; t++) begin : g_ringChk
    // R10
    ring_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrIdx[t] <= descTab[t].lenM1);
  end

endmodule

// File: rtl/corr_engine.sv
module corr_engine
  import corr_pkg::*;
#(
  parameter int CHIPS     = 4,
  parameter int TASKS     = 4,
  parameter int SAMP_W    = 8,
  parameter int ACC_W     = 16,
  parameter int OUT_DEPTH = 32,
  parameter int ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipValid,
  input  logic [SAMP_W-1:0] chipI,
  input  logic [SAMP_W-1:0] chipQ,
  input  logic [1:0]        chipScr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              overrun
);

  logic [CHIPS-1:0][SAMP_W-1:0] workI, workQ;
  logic [CHIPS-1:0][1:0]        workScr;
  ctrlStrobe_t                  strobe;

  corr_ctrl #(
    .CHIPS(CHIPS), .TASKS(TASKS), .SAMP_W(SAMP_W), .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .chipValid(chipValid), .chipI(chipI), .chipQ(chipQ),
    .chipScr(chipScr), .hostWr(hostWr), .hostAddr(hostAddr), .workI(workI),
    .workQ(workQ), .workScr(workScr), .strobe(strobe), .overrun(overrun)
  );

  corr_datapath #(
    .CHIPS(CHIPS), .TASKS(TASKS), .SAMP_W(SAMP_W), .ACC_W(ACC_W),
    .OUT_DEPTH(OUT_DEPTH), .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .workI(workI), .workQ(workQ),
    .workScr(workScr), .hostRd(hostRd), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata)
  );

endmodule

// File: tb/test_corr_engine.sv
module test_corr_engine;

  localparam int NCH = 4;
  localparam int NT  = 6;
  localparam int AW  = 10;
  localparam int DEP = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipValid = 1'b0;
  logic [7:0]  chipI = '0, chipQ = '0;
  logic [1:0]  chipScr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        overrun;

  int testCnt = 0, failCnt = 0;

  always #2 clk = ~clk;

  corr_engine #(.CHIPS(NCH), .TASKS(NT), .ACC_W(10), .OUT_DEPTH(DEP), .ADDR_W(AW))
    i_corr_engine (.*);

  // model state
  int mEn[NT], mLsf[NT], mCode[NT], mOff[NT], mBase[NT], mLenM1[NT];
  int mAccI[NT], mAccQ[NT], mPh[NT], mSt[NT], mWr[NT];
  logic [31:0] mMem[DEP];
  int vI[NCH], vQ[NCH], vS[NCH];
  logic [31:0] rnd = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int sat10(input int x);
    if (x > 511) return 511;
    if (x < -512) return -512;
    return x;
  endfunction

  function automatic bit ovsfModel(input int code, input int j, input int lsf);
    int par = 0;
    for (int b = 0; b < lsf; b++) begin
      int rb = (j >> b) & 1;
      par ^= rb & ((code >> (lsf - 1 - b)) & 1);
    end
    return par[0];
  endfunction

  task automatic writeDesc(input int t, input int en, input int lsf, input int code,
                           input int off, input int base, input int lenM1);
    logic [31:0] w;
    w = {6'(lenM1), 7'(base), 5'(off), 9'(code), 4'(lsf), 1'(en)};
    @(negedge clk);
    hostWr = 1'b1; hostAddr = AW'(t); hostWdata = w;
    @(negedge clk);
    hostWr = 1'b0;
    mEn[t] = en; mLsf[t] = lsf; mCode[t] = code; mOff[t] = off;
    mBase[t] = base; mLenM1[t] = lenM1;
    mAccI[t] = 0; mAccQ[t] = 0; mPh[t] = 0; mSt[t] = 0; mWr[t] = 0;
  endtask

  task automatic readWord(input int addr, output logic [31:0] d);
    @(negedge clk);
    hostRd = 1'b1; hostAddr = AW'(addr);
    @(negedge clk);
    hostRd = 1'b0;
    d = hostRdata;
  endtask

  task automatic modelVector();
    for (int t = 0; t < NT; t++) begin
      if (mEn[t] != 0) begin
        for (int p = 0; p < NCH; p++) begin
          if (mSt[t] != 0 || p >= mOff[t]) begin
            int sI = (vS[p] & 1) ? -1 : 1;
            int sQ = (vS[p] & 2) ? -1 : 1;
            int tI = vI[p] * sI + vQ[p] * sQ;
            int tQ = vQ[p] * sI - vI[p] * sQ;
            if (ovsfModel(mCode[t], mPh[t], mLsf[t])) begin tI = -tI; tQ = -tQ; end
            mAccI[t] = sat10(mAccI[t] + tI);
            mAccQ[t] = sat10(mAccQ[t] + tQ);
            if (mPh[t] == (1 << mLsf[t]) - 1) begin
              mMem[(mBase[t] + mWr[t]) % DEP] = 32'((mAccI[t] & 1023) | ((mAccQ[t] & 1023) << 16));
              mWr[t] = (mWr[t] == mLenM1[t]) ? 0 : mWr[t] + 1;
              mAccI[t] = 0; mAccQ[t] = 0; mPh[t] = 0;
            end else mPh[t]++;
          end
        end
        mSt[t] = 1;
      end
    end
  endtask

  // mode 0 random, 1 full positive, 2 full negative
  task automatic sendVector(input int mode, input bit gap);
    for (int p = 0; p < NCH; p++) begin
      rnd = rnd * 32'd1103515245 + 32'd12345;
      if (mode == 0) begin
        vI[p] = int'($signed(rnd[23:16])); vQ[p] = int'($signed(rnd[15:8])); vS[p] = int'(rnd[29:28]);
      end else if (mode == 1) begin
        vI[p] = 127; vQ[p] = 127; vS[p] = 0;
      end else begin
        vI[p] = -128; vQ[p] = -128; vS[p] = 0;
      end
      @(negedge clk);
      chipValid = 1'b1; chipI = 8'(vI[p]); chipQ = 8'(vQ[p]); chipScr = 2'(vS[p]);
    end
    @(negedge clk);
    chipValid = 1'b0;
    modelVector();
    if (gap) repeat (5) @(negedge clk);
  endtask

  task automatic checkMem(input string req);
    logic [31:0] d;
    repeat (10) @(negedge clk);
    for (int i = 0; i < DEP; i++) begin
      readWord(512 + i, d);
      check(d === mMem[i], req, d, mMem[i]);
    end
  endtask

  initial begin
    #(4 * 200000);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int t = 0; t < NT; t++) begin
      mEn[t] = 0; mLsf[t] = 2; mCode[t] = 0; mOff[t] = 0; mBase[t] = 0; mLenM1[t] = 0;
      mAccI[t] = 0; mAccQ[t] = 0; mPh[t] = 0; mSt[t] = 0; mWr[t] = 0;
    end
    for (int i = 0; i < DEP; i++) mMem[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(overrun === 1'b0, "R1 overrun after reset", 32'(overrun), 32'h0);
    check(hostRdata === 32'h0, "R1 read data after reset", hostRdata, 32'h0);
    readWord(3, d);
    check(d === 32'h0, "R1 descriptor disabled", d, 32'h0);
    checkMem("R1 memory clear");

    // R4 descriptor fields, R10 ring with wrap on t2, R3 t3 disabled
    writeDesc(0, 1, 2, 1, 0, 2, 3);
    writeDesc(1, 1, 3, 5, 1, 7, 2);
    writeDesc(2, 1, 4, 11, 3, 30, 3);
    writeDesc(3, 0, 3, 2, 0, 12, 3);
    writeDesc(4, 1, 9, 300, 2, 16, 1);
    writeDesc(5, 1, 4, 0, 0, 20, 7);
    readWord(2, d);
    check(d === {6'd3, 7'd30, 5'd3, 9'd11, 4'd4, 1'b1}, "R13 descriptor readback", d,
          {6'd3, 7'd30, 5'd3, 9'd11, 4'd4, 1'b1});
    for (int v = 0; v < 40; v++) sendVector(0, 1'b1);
    checkMem("R2 R5 R6 R7 R8 R10 random traffic");

    // R12 rewrite live task, R3 disable task 0
    writeDesc(1, 1, 5, 17, 2, 24, 1);
    writeDesc(0, 0, 2, 1, 0, 2, 3);
    for (int v = 0; v < 30; v++) sendVector(0, 1'b1);
    checkMem("R3 R12 rewrite and disable");

    // R9 saturation both signs
    for (int v = 0; v < 10; v++) sendVector(1, 1'b1);
    for (int v = 0; v < 10; v++) sendVector(2, 1'b1);
    checkMem("R9 saturation");

    // R7 long spreading factor on task 4
    for (int v = 0; v < 150; v++) sendVector(0, 1'b1);
    checkMem("R7 R10 long symbols");

    // R13 output region not writable
    @(negedge clk);
    hostWr = 1'b1; hostAddr = AW'(512 + 17); hostWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    hostWr = 1'b0;
    readWord(512 + 17, d);
    check(d === mMem[17], "R13 output write ignored", d, mMem[17]);

    // R11 overrun
    check(overrun === 1'b0, "R11 no overrun on gapped traffic", 32'(overrun), 32'h0);
    for (int v = 0; v < 3; v++) sendVector(0, 1'b0);
    repeat (10) @(negedge clk);
    check(overrun === 1'b1, "R11 overrun on burst", 32'(overrun), 32'h1);
    sendVector(0, 1'b1);
    repeat (10) @(negedge clk);
    check(overrun === 1'b1, "R11 overrun sticky", 32'(overrun), 32'h1);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule